// File: doc/BRIEF.md
# Quasi-Bidirectional GPIO Port Controller

This block holds the digital control side of a general-purpose I/O port of `WIDTH` pins (eight by default). Each pin is configured by one bit in an open-drain register and one bit in a pull-up register. Together these two bits select one of four pin modes. From the output latch, the selected mode and the synchronized pin level, the block produces four enables per pin: a high-side driver, a low-side driver, a strong pull-up and a weak pull-up. The analog pad, the input buffer and the pull-up devices sit outside and are steered by these enables.

The quasi-bidirectional mode is the reset mode. In this mode a pin behaves as an open-drain output with a weak pull-up. When its latch changes from 0 to 1, the high-side driver is switched on for a short, fixed boost of `BOOST_CYCLES` clocks so that the pin rises quickly. The strong pull-up tracks the pin's own synchronized level, so a pin that reads high is held high firmly. A pin that is pulled low only fights the weak pull-up.

A small register interface with a two-bit address writes and reads the latch and both mode registers. It also reads the synchronized pin levels. All four enables are registered.

Top module: `qbp_port`

## Requirements
- R1: Mode bits are formed as {od, pu}. With mode 00 (input), all four enables of the pin are 0 whatever the latch holds.
- R2: With mode 01 (push-pull), the high-side enable equals the latch bit and the low-side enable equals its inverse. Neither pull-up is enabled. All enables reflect a register write on the second clock edge after the write edge.
- R3: With mode 10 (open-drain), the high-side enable is always 0, the low-side enable is the inverse of the latch bit, and neither pull-up is enabled.
- R4: With mode 11 (quasi-bidirectional), the low-side enable is the inverse of the latch bit. A 0-to-1 latch change raises the high-side enable from the second edge after the write edge, for exactly BOOST_CYCLES clocks (default 2).
- R5: A 1-to-0 latch change during a boost ends it at once: the next output update shows the high-side enable 0 and the low-side enable 1. A later 0-to-1 change starts a complete new boost.
- R6: The high-side and low-side enables of a pin are never 1 in the same cycle.
- R7: With mode 11, the weak pull-up enable is 1. The strong pull-up enable equals the pin input after a two-flop synchronizer, so a pin change shows on the third clock edge after it.
- R8: The register addresses are 0 for the latch, 1 for the od bits, 2 for the pu bits and 3 for the synchronized pin levels. Address 3 is read-only, and writes to it change nothing. Read data appears one clock edge after the address is presented.
- R9: After reset, every pin is in mode 11 with its latch at 1 and both mode registers all ones. The high-side and low-side enables are 0, so the reset itself produces no boost.
- R10: Each pin follows its own mode bits and latch bit, independent of the other pins.
- R11: Writing 1 to a latch bit that already holds 1 does not start a boost. Switching a pin whose latch is already 1 into mode 11 does not start one either.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | WIDTH | Register write data |
| reg_rdata_o | output | WIDTH | Registered read data |
| pin_i | input | WIDTH | Raw pin levels from the input buffers |
| drv_hi_o | output | WIDTH | High-side driver enables |
| drv_lo_o | output | WIDTH | Low-side driver enables |
| pu_strong_o | output | WIDTH | Strong pull-up enables |
| pu_weak_o | output | WIDTH | Weak pull-up enables |

## Verification
The in-RTL properties check, on every cycle, that the two drivers of a pin never conflict. They also check that push-pull and input-mode outputs follow the previous cycle's mode and latch, that the quasi mode keeps the weak pull-up on and mirrors the synchronized level in the strong one, that a high-side run in quasi mode never exceeds the boost length, and that writes to the read-only address leave the registers unchanged. What the properties cannot show is that a boost actually starts on the intended edge and lasts the full length, that it restarts after a cancel, that no boost appears after reset, after rewriting a 1 or after a mode switch, and the exact synchronizer latency. The directed scenarios in the bench cover these cases.

// File: rtl/qbp_pkg.sv
package qbp_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    MODE_INPUT     = 2'b00,
    MODE_PUSHPULL  = 2'b01,
    MODE_OPENDRAIN = 2'b10,
    MODE_QUASI     = 2'b11
  } pin_mode_e;

  typedef enum logic [ADDR_W-1:0] {
    REG_LATCH = 2'd0,
    REG_OD    = 2'd1,
    REG_PU    = 2'd2,
    REG_PINS  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic hi;
    logic lo;
    logic ps;
    logic pw;
  } pin_en_t;

endpackage

// File: rtl/qbp_sync.sv
module qbp_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/qbp_regs.sv
module qbp_regs
  import qbp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  pin_sync_i,
  output logic [WIDTH-1:0]  lat_o,
  output logic [WIDTH-1:0]  od_o,
  output logic [WIDTH-1:0]  pu_o,
  output logic [WIDTH-1:0]  rdata_o
);

  logic [WIDTH-1:0] lat_q, od_q, pu_q, rdata_q;
  logic [WIDTH-1:0] rd_mux;
  reg_addr_e        sel;

  assign sel = reg_addr_e'(addr_i);

  always_comb begin
    unique case (sel)
      REG_LATCH: rd_mux = lat_q;
      REG_OD:    rd_mux = od_q;
      REG_PU:    rd_mux = pu_q;
      default:   rd_mux = pin_sync_i;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lat_q   <= '1;
      od_q    <= '1;
      pu_q    <= '1;
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_mux;
      if (we_i) begin
        unique case (sel)
          REG_LATCH: lat_q <= wdata_i;
          REG_OD:    od_q  <= wdata_i;
          REG_PU:    pu_q  <= wdata_i;
          default:   ;
        endcase
      end
    end
  end

  assign lat_o   = lat_q;
  assign od_o    = od_q;
  assign pu_o    = pu_q;
  assign rdata_o = rdata_q;

  // R8: the pin-level address is read-only
  p_pins_read_only_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (we_i && sel == REG_PINS) |=> ($stable(lat_q) && $stable(od_q) && $stable(pu_q)));

endmodule

// File: rtl/qbp_pin_ctl.sv
module qbp_pin_ctl
  import qbp_pkg::*;
#(
  parameter int BOOST_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic od_i,
  input  logic pu_i,
  input  logic lat_i,
  input  logic pin_sync_i,
  output logic hi_o,
  output logic lo_o,
  output logic ps_o,
  output logic pw_o
);

  localparam int CW = $clog2(BOOST_CYCLES + 1);
  localparam logic [CW-1:0] BOOST_LOAD = CW'(BOOST_CYCLES);

  pin_mode_e mode;
  logic      lat_d_q;
  logic      rise;
  logic [CW-1:0] cnt_q, cnt_n;
  pin_en_t   en_n, en_q;

  assign mode = pin_mode_e'({od_i, pu_i});
  assign rise = lat_i & ~lat_d_q;

  // boost counter: loads on a rising latch, clears on a falling latch or
  // when the pin leaves the quasi-bidirectional mode
  always_comb begin
    cnt_n = cnt_q;
    if (mode != MODE_QUASI || !lat_i) begin
      cnt_n = '0;
    end else if (rise) begin
      cnt_n = BOOST_LOAD;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_comb begin
    en_n = '0;
    unique case (mode)
      MODE_INPUT: en_n = '0;
      MODE_PUSHPULL: begin
        en_n.hi = lat_i;
        en_n.lo = ~lat_i;
      end
      MODE_OPENDRAIN: begin
        en_n.lo = ~lat_i;
      end
      default: begin
        en_n.hi = (cnt_n != '0);
        en_n.lo = ~lat_i;
        en_n.ps = pin_sync_i;
        en_n.pw = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lat_d_q <= 1'b1;
      cnt_q   <= '0;
      en_q    <= '{hi: 1'b0, lo: 1'b0, ps: 1'b0, pw: 1'b1};
    end else begin
      lat_d_q <= lat_i;
      cnt_q   <= cnt_n;
      en_q    <= en_n;
    end
  end

  assign hi_o = en_q.hi;
  assign lo_o = en_q.lo;
  assign ps_o = en_q.ps;
  assign pw_o = en_q.pw;

  // checker state: length of a high-side run produced in quasi mode
  logic          quasi_d_q;
  logic [CW:0]   hi_run_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      quasi_d_q <= 1'b1;
      hi_run_q  <= '0;
    end else begin
      quasi_d_q <= (mode == MODE_QUASI);
      if (en_n.hi && mode == MODE_QUASI) begin
        if (hi_run_q != '1) hi_run_q <= hi_run_q + 1'b1;
      end else begin
        hi_run_q <= '0;
      end
    end
  end

  p_no_contention_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !(hi_o && lo_o));

  p_input_idle_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i) && $past(mode == MODE_INPUT)) |-> (!hi_o && !lo_o && !ps_o && !pw_o));

  p_push_pull_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i) && $past(mode == MODE_PUSHPULL)) |-> (hi_o == $past(lat_i) && lo_o == !$past(lat_i)));

  p_quasi_pull_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i) && quasi_d_q) |-> (pw_o && ps_o == $past(pin_sync_i)));

  p_boost_bounded_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    hi_run_q <= (CW+1)'(BOOST_CYCLES));

endmodule

// File: rtl/qbp_port.sv
module qbp_port
  import qbp_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int BOOST_CYCLES = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [WIDTH-1:0]  reg_wdata_i,
  output logic [WIDTH-1:0]  reg_rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  drv_hi_o,
  output logic [WIDTH-1:0]  drv_lo_o,
  output logic [WIDTH-1:0]  pu_strong_o,
  output logic [WIDTH-1:0]  pu_weak_o
);

  logic [WIDTH-1:0] pin_sync, lat, od, pu;

  qbp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  qbp_regs #(.WIDTH(WIDTH)) i_regs (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .pin_sync_i (pin_sync),
    .lat_o      (lat),
    .od_o       (od),
    .pu_o       (pu),
    .rdata_o    (reg_rdata_o)
  );

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    qbp_pin_ctl #(.BOOST_CYCLES(BOOST_CYCLES)) i_pin (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .od_i       (od[p]),
      .pu_i       (pu[p]),
      .lat_i      (lat[p]),
      .pin_sync_i (pin_sync[p]),
      .hi_o       (drv_hi_o[p]),
      .lo_o       (drv_lo_o[p]),
      .ps_o       (pu_strong_o[p]),
      .pw_o       (pu_weak_o[p])
    );
  end

endmodule

// File: tb/test_qbp_port.sv
`timescale 1ns/1ps
module test_qbp_port;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         we = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [W-1:0] pin = '0;
  logic [W-1:0] hi, lo, ps, pw;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  qbp_port #(.WIDTH(W), .BOOST_CYCLES(2), .SYNC_STAGES(2)) i_qbp_port (
    .clk_i       (clk),
    .rst_i       (rst),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .pin_i       (pin),
    .drv_hi_o    (hi),
    .drv_lo_o    (lo),
    .pu_strong_o (ps),
    .pu_weak_o   (pw)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; the write is taken on the next posedge
  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    rst = 1'b1;
    step(4);
    rst = 1'b0;
    chk("R9 hi after reset", 32'(hi), 32'h00);
    chk("R9 lo after reset", 32'(lo), 32'h00);
    chk("R9 weak pull after reset", 32'(pw), 32'hFF);
    step(3);
    chk("R9 no boost from reset", 32'(hi), 32'h00);
    rd(2'd0, v); chk("R9 latch reset", 32'(v), 32'hFF);
    rd(2'd1, v); chk("R9 od reset", 32'(v), 32'hFF);
    rd(2'd2, v); chk("R9 pu reset", 32'(v), 32'hFF);
  endtask

  task automatic t_regs;
    logic [W-1:0] v;
    wr(2'd1, 8'h5A); rd(2'd1, v); chk("R8 od readback", 32'(v), 32'h5A);
    wr(2'd2, 8'hC3); rd(2'd2, v); chk("R8 pu readback", 32'(v), 32'hC3);
    wr(2'd0, 8'h81); rd(2'd0, v); chk("R8 latch readback", 32'(v), 32'h81);
    wr(2'd3, 8'h00);
    rd(2'd1, v); chk("R8 od after pin-addr write", 32'(v), 32'h5A);
    rd(2'd2, v); chk("R8 pu after pin-addr write", 32'(v), 32'hC3);
    rd(2'd0, v); chk("R8 latch after pin-addr write", 32'(v), 32'h81);
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); wr(2'd0, 8'hFF);
    step(3);
  endtask

  task automatic t_input;
    wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h00);
    step(2);
    chk("R1 input hi", 32'(hi), 0); chk("R1 input lo", 32'(lo), 0);
    chk("R1 input pulls", 32'({ps, pw}), 0);
    wr(2'd0, 8'hFF); step(2);
    chk("R1 input hi latch=1", 32'(hi), 0); chk("R1 input lo latch=1", 32'(lo), 0);
  endtask

  task automatic t_push_pull;
    wr(2'd2, 8'hFF);
    wr(2'd0, 8'hA5);
    chk("R2 not yet updated", 32'(hi), 32'hFF);
    step(1);
    chk("R2 hi", 32'(hi), 32'hA5); chk("R2 lo", 32'(lo), 32'h5A);
    chk("R2 pulls", 32'({ps, pw}), 0);
    chk("R6 push-pull overlap", 32'(hi & lo), 0);
  endtask

  task automatic t_open_drain;
    wr(2'd1, 8'hFF); wr(2'd2, 8'h00); wr(2'd0, 8'h3C);
    step(2);
    chk("R3 hi", 32'(hi), 0); chk("R3 lo", 32'(lo), 32'hC3);
    chk("R3 pulls", 32'({ps, pw}), 0);
  endtask

  task automatic t_quasi_boost;
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); wr(2'd0, 8'h00);
    step(3);
    chk("R4 lo with latch 0", 32'(lo), 32'hFF);
    wr(2'd0, 8'h0F);
    chk("R4 boost not before 2nd edge", 32'(hi), 0);
    step(1); chk("R4 boost cycle 1", 32'(hi), 32'h0F);
    chk("R6 boost overlap", 32'(hi & lo), 0);
    step(1); chk("R4 boost cycle 2", 32'(hi), 32'h0F);
    step(1); chk("R4 boost ended", 32'(hi), 0);
    chk("R4 lo after boost", 32'(lo), 32'hF0);
    wr(2'd0, 8'h0F);
    step(1); chk("R11 rewrite 1 no boost", 32'(hi), 0);
    step(1); chk("R11 rewrite 1 no boost later", 32'(hi), 0);
  endtask

  task automatic t_cancel;
    wr(2'd0, 8'h00); step(3);
    wr(2'd0, 8'h01);
    step(1); chk("R5 boost started", 32'(hi), 32'h01);
    wr(2'd0, 8'h00);
    chk("R5 boost before cancel edge", 32'(hi), 32'h01);
    step(1);
    chk("R5 cancel hi", 32'(hi), 0); chk("R5 cancel lo", 32'(lo), 32'hFF);
    wr(2'd0, 8'h01);
    step(1); chk("R5 restart cycle 1", 32'(hi), 32'h01);
    step(1); chk("R5 restart cycle 2", 32'(hi), 32'h01);
    step(1); chk("R5 restart ended", 32'(hi), 0);
  endtask

  task automatic t_pull;
    logic [W-1:0] v;
    wr(2'd0, 8'hFF); step(4);
    pin = 8'h96;
    step(2);
    chk("R7 strong before sync latency", 32'(ps), 0);
    step(1);
    chk("R7 strong follows pin", 32'(ps), 32'h96);
    chk("R7 weak on", 32'(pw), 32'hFF);
    rd(2'd3, v); chk("R8 pin readback", 32'(v), 32'h96);
    pin = 8'h00; step(4);
    chk("R7 strong off", 32'(ps), 0);
  endtask

  task automatic t_mixed;
    // pins 0..3 per nibble: input, push-pull, open-drain, quasi
    wr(2'd1, 8'hCC); wr(2'd2, 8'hAA); wr(2'd0, 8'h00);
    step(3);
    chk("R10 mixed lo", 32'(lo), 32'hEE);
    chk("R10 mixed hi", 32'(hi), 0);
    chk("R10 mixed weak", 32'(pw), 32'h88);
    wr(2'd0, 8'hFF);
    step(1); chk("R10 mixed hi with boost", 32'(hi), 32'hAA);
    chk("R6 mixed overlap", 32'(hi & lo), 0);
    step(2); chk("R10 mixed hi after boost", 32'(hi), 32'h22);
    chk("R10 mixed lo latch 1", 32'(lo), 0);
  endtask

  task automatic t_mode_switch;
    wr(2'd1, 8'h00); wr(2'd2, 8'hFF); wr(2'd0, 8'hFF);
    step(2);
    chk("R11 push-pull high before switch", 32'(hi), 32'hFF);
    wr(2'd1, 8'hFF);
    step(1); chk("R11 switch into quasi no boost", 32'(hi), 0);
    step(1); chk("R11 switch no boost later", 32'(hi), 0);
  endtask

  initial begin
    step(1);
    t_reset();
    t_regs();
    t_input();
    t_push_pull();
    t_open_drain();
    t_quasi_boost();
    t_cancel();
    t_pull();
    t_mixed();
    t_mode_switch();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule